// File: doc/BRIEF.md
# PS/2 Keyboard Scan-Code Receiver

This block takes the two open-collector lines of a PS/2 keyboard port, a slow device-driven clock and a data line, and recovers the scan codes the keyboard sends toward the host. Both lines are first brought into the system clock domain through a synchronizer. The clock line then passes through a run-length filter so that ringing or short glitches do not count as edges. Each accepted high-to-low transition of the filtered clock samples the data line.

A frame has eleven bits. The first is a start bit, which is low. Eight code bits follow, least significant first. Then comes an odd parity bit, and last a high stop bit. When a frame completes, the assembled byte appears on `code_o` together with a one-cycle `valid_o` strobe and a parity-error flag. Both outputs hold until the next completed frame. A watchdog on the frame position returns the receiver to idle if the device stops clocking in the middle of a frame. The enable input parks the receiver in idle.

Top module: `kbd_scan_rx`

## Requirements
- R1: After reset, `code_o` is 0x00, `valid_o` is 0 and `par_err_o` is 0.
- R2: A falling edge of the filtered clock with data low while idle begins a frame. The next eight falling edges deliver code bits with bit 0 first. `valid_o` pulses high for exactly one cycle after the eleventh falling edge, and `code_o` then carries the assembled byte.
- R3: `par_err_o` is 0 when the eight code bits plus the tenth (parity) bit contain an odd number of ones, and 1 otherwise. `valid_o` is raised in both cases. Code 0x29 with parity bit 0 is clean.
- R4: A frame whose eleventh bit is low produces no strobe, leaves `code_o` and `par_err_o` unchanged, and returns the receiver to idle.
- R5: The filtered clock takes a new level only after 8 consecutive system-clock samples at that level. Shorter pulses of either polarity on `ps2_clk_i` neither shift the frame nor add bits.
- R6: If a frame is in progress and no falling edge arrives for TIMEOUT_CYC system cycles (5000 by default, 100 us at 50 MHz), the receiver returns to idle. A later frame is then received correctly.
- R7: While `en_i` is low, falling edges are ignored, any partial frame is dropped, and `valid_o` stays low.
- R8: While idle, a falling edge with data high does not begin a frame.
- R9: `code_o` and `par_err_o` change only in the cycle in which `valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Receive enable |
| ps2_clk_i | input | 1 | PS/2 clock line from the device |
| ps2_data_i | input | 1 | PS/2 data line from the device |
| code_o | output | 8 | Last received scan code |
| valid_o | output | 1 | One-cycle strobe when a frame is completed |
| par_err_o | output | 1 | Parity mismatch in the last completed frame |

## Verification
The hardest situation to reach from the ports is the mid-frame watchdog. It needs a frame that stops after a few bits and a silence longer than TIMEOUT_CYC. The bench sends a truncated frame of start plus three bits, waits past the limit, and then sends a full frame. If the watchdog failed, that full frame would be misaligned by four bits and decode to a different byte. Glitch rejection is exercised by injecting sub-threshold pulses of both polarities inside the clock phases of a complete frame, which must still decode exactly.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
  localparam int unsigned CODE_W    = 8;
  localparam int unsigned FRAME_LEN = CODE_W + 3;  // start, data, parity, stop
  localparam int unsigned IDX_W     = $clog2(FRAME_LEN);

  typedef logic [CODE_W-1:0] scan_code_t;
  typedef logic [IDX_W-1:0]  bit_idx_t;

  localparam bit_idx_t IDX_IDLE   = bit_idx_t'(0);
  localparam bit_idx_t IDX_LAST_D = bit_idx_t'(CODE_W);
  localparam bit_idx_t IDX_PAR    = bit_idx_t'(CODE_W + 1);

  function automatic logic par_bad(scan_code_t code, logic par);
    return ~(^{code, par});
  endfunction
endpackage

// File: rtl/kbd_line_sync.sv
module kbd_line_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe <= '1;  // idle lines are high
      else         pipe <= {pipe[STAGES-2:0], din_i[g]};
    end
    assign dout_o[g] = pipe[STAGES-1];
  end
endmodule

// File: rtl/kbd_clk_filter.sv
module kbd_clk_filter #(
  parameter int unsigned FILT_LEN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic fall_o
);
  localparam int unsigned CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] RUN_MAX = CW'(FILT_LEN - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o <= 1'b1;
      run_q   <= '0;
      fall_o  <= 1'b0;
    end else begin
      fall_o <= 1'b0;
      if (line_i != level_o) begin
        if (run_q == RUN_MAX) begin
          level_o <= line_i;
          run_q   <= '0;
          fall_o  <= level_o;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end else begin
        run_q <= '0;
      end
    end
  end
endmodule

// File: rtl/kbd_frame_fsm.sv
module kbd_frame_fsm
  import kbd_scan_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 5000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       fall_i,
  input  logic       data_i,
  output bit_idx_t   bit_idx_o,
  output scan_code_t code_o,
  output logic       valid_o,
  output logic       par_err_o
);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TW-1:0] TO_MAX = TW'(TIMEOUT_CYC - 1);

  bit_idx_t      idx_q;
  scan_code_t    shift_q;
  logic          par_q;
  logic [TW-1:0] quiet_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= IDX_IDLE;
      shift_q   <= '0;
      par_q     <= 1'b0;
      quiet_q   <= '0;
      code_o    <= '0;
      valid_o   <= 1'b0;
      par_err_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (!en_i) begin
        idx_q   <= IDX_IDLE;
        quiet_q <= '0;
      end else if (fall_i) begin
        quiet_q <= '0;
        if (idx_q == IDX_IDLE) begin
          if (!data_i) idx_q <= idx_q + 1'b1;
        end else if (idx_q <= IDX_LAST_D) begin
          shift_q <= {data_i, shift_q[CODE_W-1:1]};  // LSB arrives first
          idx_q   <= idx_q + 1'b1;
        end else if (idx_q == IDX_PAR) begin
          par_q <= data_i;
          idx_q <= idx_q + 1'b1;
        end else begin
          idx_q <= IDX_IDLE;
          if (data_i) begin
            valid_o   <= 1'b1;
            code_o    <= shift_q;
            par_err_o <= par_bad(shift_q, par_q);
          end
        end
      end else if (idx_q != IDX_IDLE) begin
        if (quiet_q == TO_MAX) begin
          idx_q   <= IDX_IDLE;
          quiet_q <= '0;
        end else begin
          quiet_q <= quiet_q + 1'b1;
        end
      end
    end
  end

  assign bit_idx_o = idx_q;
endmodule

// File: rtl/kbd_scan_rx.sv
module kbd_scan_rx
  import kbd_scan_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 8,
  parameter int unsigned TIMEOUT_CYC = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              ps2_clk_i,
  input  logic              ps2_data_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o,
  output logic              par_err_o
);
  logic [1:0] lines_s;
  logic       clk_s, dat_s, clk_f, fall;
  bit_idx_t   bit_cnt;

  kbd_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni,
    .din_i ({ps2_data_i, ps2_clk_i}),
    .dout_o(lines_s)
  );
  assign clk_s = lines_s[0];
  assign dat_s = lines_s[1];

  kbd_clk_filter #(.FILT_LEN(FILT_LEN)) i_filt (
    .clk_i, .rst_ni,
    .line_i (clk_s),
    .level_o(clk_f),
    .fall_o (fall)
  );

  kbd_frame_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_fsm (
    .clk_i, .rst_ni, .en_i,
    .fall_i   (fall),
    .data_i   (dat_s),
    .bit_idx_o(bit_cnt),
    .code_o   (code_o),
    .valid_o  (valid_o),
    .par_err_o(par_err_o)
  );
endmodule

// File: rtl/kbd_scan_rx_chk.sv
module kbd_scan_rx_chk
  import kbd_scan_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 5000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       valid_o,
  input scan_code_t code_o,
  input logic       par_err_o,
  input logic       clk_s,
  input logic       clk_f,
  input logic       fall,
  input bit_idx_t   bit_cnt
);
  localparam int unsigned TW = $clog2(TIMEOUT_CYC + 2);
  logic [TW-1:0] quiet_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) quiet_run <= '0;
    else if (en_i && !fall && bit_cnt != IDX_IDLE) quiet_run <= quiet_run + 1'b1;
    else quiet_run <= '0;
  end

  a_r2_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r2_strobe_after_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(fall));
  a_r5_filter_follows_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(clk_f) |-> ($past(clk_s) == clk_f));
  a_r6_frame_watchdog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cnt != IDX_IDLE) |-> (quiet_run < TW'(TIMEOUT_CYC)));
  a_r7_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);
  a_r9_hold_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(code_o) && $stable(par_err_o)));
endmodule

bind kbd_scan_rx kbd_scan_rx_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .valid_o  (valid_o),
  .code_o   (code_o),
  .par_err_o(par_err_o),
  .clk_s    (clk_s),
  .clk_f    (clk_f),
  .fall     (fall),
  .bit_cnt  (bit_cnt)
);

// File: tb/test_kbd_scan_rx.sv
`timescale 1ns/1ps
module test_kbd_scan_rx;
  localparam int HALF    = 16;    // PS/2 half period in system cycles
  localparam int TIMEOUT = 5000;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, pclk = 1'b1, pdat = 1'b1;
  logic [7:0] code;
  logic valid, perr;
  int total = 0, bad = 0, vcount = 0;
  logic [7:0] last_code = 8'h00;
  logic last_err = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  kbd_scan_rx #(.TIMEOUT_CYC(TIMEOUT)) i_kbd_scan_rx (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .ps2_clk_i(pclk), .ps2_data_i(pdat),
    .code_o(code), .valid_o(valid), .par_err_o(perr)
  );

  always @(negedge clk) if (valid) begin
    vcount++; last_code = code; last_err = perr;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  // nbits: how many of the 11 frame bits to send; glitch adds short pulses in both phases
  task automatic frame(input logic [7:0] d, input logic par, input logic stp,
                       input bit glitch, input int nbits);
    logic [10:0] b;
    b = {stp, par, d, 1'b0};
    for (int i = 0; i < nbits; i++) begin
      pdat = b[i];
      if (glitch) begin
        cyc(4); pclk = 1'b0; cyc(5); pclk = 1'b1; cyc(HALF);
      end else cyc(HALF);
      pclk = 1'b0;
      if (glitch) begin
        cyc(4); pclk = 1'b1; cyc(5); pclk = 1'b0; cyc(HALF);
      end else cyc(HALF);
      pclk = 1'b1;
    end
    cyc(HALF); pdat = 1'b1; cyc(40);
  endtask

  function automatic logic odd_par(input logic [7:0] d);
    return ~(^d);
  endfunction

  task automatic expect_frame(input logic [7:0] d, input logic par, input string req,
                              input bit glitch);
    int v0;
    v0 = vcount;
    frame(d, par, 1'b1, glitch, 11);
    chk(vcount == v0 + 1, {req, " strobe count"}, vcount - v0, 1);
    chk(last_code == d, {req, " code"}, last_code, d);
    chk(last_err == (par != odd_par(d)), {req, " parity flag"}, last_err, par != odd_par(d));
  endtask

  initial begin
    cyc(190000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v0;
    cyc(3);
    #2;
    // R1 reset state
    chk(code == 8'h00 && !valid && !perr, "R1 reset outputs", {code, valid, perr}, 0);
    rst_n = 1'b1;
    cyc(5);

    // R2 exhaustive code sweep with correct parity
    for (int c = 0; c < 256; c++) expect_frame(8'(c), odd_par(8'(c)), "R2", 1'b0);

    // R3 wrong parity sweep, and the spacebar code
    for (int c = 0; c < 256; c += 17) expect_frame(8'(c), ~odd_par(8'(c)), "R3", 1'b0);
    expect_frame(8'h29, 1'b0, "R3 spacebar", 1'b0);

    // R4 low stop bit: no strobe, outputs held (R9)
    v0 = vcount;
    frame(8'h5A, odd_par(8'h5A), 1'b0, 1'b0, 11);
    chk(vcount == v0, "R4 no strobe", vcount - v0, 0);
    chk(code == 8'h29 && !perr, "R9 held after bad stop", code, 8'h29);
    expect_frame(8'hC3, odd_par(8'hC3), "R4 recovery", 1'b0);

    // R5 sub-threshold glitches of both polarities
    expect_frame(8'h96, odd_par(8'h96), "R5 glitch", 1'b1);
    expect_frame(8'h01, ~odd_par(8'h01), "R5 glitch parity", 1'b1);

    // R6 truncated frame then silence past the limit
    frame(8'hFF, 1'b1, 1'b1, 1'b0, 4);
    cyc(TIMEOUT + 100);
    expect_frame(8'h4E, odd_par(8'h4E), "R6 after timeout", 1'b0);

    // R7 disabled frame, then partial frame aborted by enable drop
    en = 1'b0;
    v0 = vcount;
    frame(8'h77, odd_par(8'h77), 1'b1, 1'b0, 11);
    chk(vcount == v0, "R7 disabled no strobe", vcount - v0, 0);
    chk(code == 8'h4E, "R7 code held", code, 8'h4E);
    en = 1'b1;
    frame(8'hFF, 1'b1, 1'b1, 1'b0, 5);
    en = 1'b0; cyc(10); en = 1'b1; cyc(5);
    expect_frame(8'h3C, odd_par(8'h3C), "R7 after abort", 1'b0);

    // R8 falling edge with data high in idle
    pdat = 1'b1; cyc(HALF); pclk = 1'b0; cyc(HALF); pclk = 1'b1; cyc(40);
    expect_frame(8'hA5, odd_par(8'hA5), "R8 after idle edge", 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule